// File: doc/BRIEF.md
# Trace Buffer Partition Label Register

This block keeps a 64-bit control word that decides which memory-partitioning labels go with the writes a trace buffer makes to memory. There are three labels: a partition identifier, a monitoring group and an identifier space. Software writes the word through a simple write/read port. A mode input says whether the buffer is run by software on the same processor (self-hosted) or by an external debugger (external). Two enable inputs reflect the buffer's own enable bits. Writes that arrive while the relevant enable is set are dropped, so a running buffer keeps its labels.

For every trace beat, the block produces the labels that go with the memory write. In self-hosted mode the programmed fields play no part and the default labels apply. In external mode the programmed labels apply only when the label-enable bit is set. Otherwise the defaults apply and the identifier space follows the buffer's physical-address-space attribute. In external mode the block also decides whether the beat may be written. A beat is dropped, and a one-cycle management event is raised, when the chosen space is not implemented or when debug of its security domain is not authorised. The decision is combinational and is made in the same cycle as the beat's valid.

Top module: `trc_label_reg`

## Requirements
- R1: Reading gives the stored word laid out as follows: label-enable at bit 26, identifier space at bits 25:24, monitoring group at bits 23:16 and partition identifier at bits 15:0. Bits 63:27 read as zero.
- R2: After a synchronous reset (rst_n low at a clock edge), the label-enable bit reads 0. The other fields have no defined reset value.
- R3: Only the low bits needed to hold PART_MAX are kept in the partition field, and only the low bits needed to hold GRP_MAX are kept in the group field. The bits above them read as zero.
- R4: A write is dropped when buf_en is 1 and either external mode is not supported (HAS_EXT=0) or mode_ext is 0.
- R5: A write is dropped when xbuf_en is 1, HAS_EXT=1 and mode_ext is 1. A write that is not dropped shows on the read port from the next cycle.
- R6: In external mode with label-enable 0, out_part and out_grp are 0 and out_spc equals buf_pas.
- R7: In external mode with label-enable 1, the outputs carry the stored partition, group and space.
- R8: In self-hosted mode, or when HAS_EXT=0, the stored labels are ignored. The outputs are 0, 0 and buf_pas, and every valid beat is written.
- R9: Space encodings are 00 secure, 01 non-secure, 10 root and 11 realm. In external mode, a beat is dropped with an event when the space is 00 and HAS_SECURE=0, or when the space is 10 or 11 and HAS_REALM=0.
- R10: In external mode, a beat is dropped with an event when dbg_all is 0. It is also dropped when HAS_SECURE=1, dbg_sec is 0 and the space is 00; when HAS_REALM=1, dbg_root is 0 and the space is 10; or when HAS_REALM=1, dbg_realm is 0 and the space is 11.
- R11: For a valid beat, exactly one of beat_wr and beat_drop_evt is high, in the same cycle as beat_vld. Both are low when no beat is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data |
| mode_ext | input | 1 | 1 = external mode, 0 = self-hosted mode |
| buf_en | input | 1 | Buffer enable bit used in self-hosted mode |
| xbuf_en | input | 1 | Buffer enable bit used in external mode |
| dbg_all | input | 1 | General invasive debug allowed |
| dbg_sec | input | 1 | Secure-domain debug allowed |
| dbg_root | input | 1 | Root-domain debug allowed |
| dbg_realm | input | 1 | Realm-domain debug allowed |
| buf_pas | input | 2 | Physical address space of the trace buffer |
| beat_vld | input | 1 | A trace beat is present |
| beat_wr | output | 1 | The beat may be written |
| beat_drop_evt | output | 1 | The beat is dropped; management event |
| out_part | output | 16 | Effective partition identifier |
| out_grp | output | 8 | Effective monitoring group |
| out_spc | output | 2 | Effective identifier space |

## Verification
The label path and the drop decision are swept over every combination of mode, address-space attribute, the four debug permissions and beat valid. The sweep is repeated for the stored word with the enable clear and with the enable set in each of the four spaces. This separates the default labels from the programmed ones and separates self-hosted from external behaviour. Running the sweep on two builds, one with the secure and realm domains and one without, tells a reserved space apart from a prohibited one. Writes are tried under each combination of enable bit and mode, including on a build without external-mode support, so each drop rule is seen both where it applies and where it does not.

// File: rtl/trc_label_pkg.sv
package trc_label_pkg;

  typedef enum logic [1:0] {
    SPC_SEC   = 2'b00,
    SPC_NSEC  = 2'b01,
    SPC_ROOT  = 2'b10,
    SPC_REALM = 2'b11
  } spc_e;

  localparam int EN_BIT  = 26;
  localparam int SPC_LSB = 24;
  localparam int GRP_LSB = 16;

  localparam logic [15:0] DEF_PART = 16'd0;
  localparam logic [7:0]  DEF_GRP  = 8'd0;

  // space encoding with no implemented security state behind it
  function automatic logic spc_reserved(input logic [1:0] s,
                                        input logic has_sec,
                                        input logic has_realm);
    case (spc_e'(s))
      SPC_SEC:   return !has_sec;
      SPC_NSEC:  return 1'b0;
      default:   return !has_realm;
    endcase
  endfunction

  // debug authorisation withheld for the domain selected by the space
  function automatic logic spc_denied(input logic [1:0] s,
                                      input logic has_sec,
                                      input logic has_realm,
                                      input logic en_all,
                                      input logic en_sec,
                                      input logic en_root,
                                      input logic en_realm);
    logic d;
    d = !en_all;
    if (has_sec && !en_sec && spc_e'(s) == SPC_SEC)       d = 1'b1;
    if (has_realm && !en_root && spc_e'(s) == SPC_ROOT)   d = 1'b1;
    if (has_realm && !en_realm && spc_e'(s) == SPC_REALM) d = 1'b1;
    return d;
  endfunction

endpackage

// File: rtl/trc_label_store.sv
module trc_label_store #(
  parameter int PW      = 4,
  parameter int GW      = 2,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          w_en,
  input  logic [1:0]    w_spc,
  input  logic [7:0]    w_grp,
  input  logic [15:0]   w_part,
  input  logic          mode_ext,
  input  logic          buf_en,
  input  logic          xbuf_en,
  output logic          wr_accept,
  output logic          lab_en,
  output logic [1:0]    lab_spc,
  output logic [GW-1:0] lab_grp,
  output logic [PW-1:0] lab_part
);

  logic wr_locked;
  logic unused_hi;

  assign wr_locked = (buf_en && (!HAS_EXT || !mode_ext)) ||
                     (xbuf_en && HAS_EXT && mode_ext);
  assign wr_accept = rst_n && wr && !wr_locked;
  assign unused_hi = ^{w_grp >> GW, w_part >> PW};

  always_ff @(posedge clk) begin
    if (!rst_n)         lab_en <= 1'b0;
    else if (wr_accept) lab_en <= w_en;
  end

  always_ff @(posedge clk) begin
    if (wr_accept) begin
      lab_spc  <= w_spc;
      lab_grp  <= w_grp[GW-1:0];
      lab_part <= w_part[PW-1:0];
    end
  end

endmodule

// File: rtl/trc_label_sel.sv
module trc_label_sel
  import trc_label_pkg::*;
#(
  parameter int PW = 4,
  parameter int GW = 2
) (
  input  logic          ext_act,
  input  logic          lab_en,
  input  logic [1:0]    lab_spc,
  input  logic [GW-1:0] lab_grp,
  input  logic [PW-1:0] lab_part,
  input  logic [1:0]    buf_pas,
  output logic [15:0]   eff_part,
  output logic [7:0]    eff_grp,
  output logic [1:0]    eff_spc
);

  logic use_prog;
  assign use_prog = ext_act && lab_en;

  always_comb begin
    if (use_prog) begin
      eff_part = 16'(lab_part);
      eff_grp  = 8'(lab_grp);
      eff_spc  = lab_spc;
    end else begin
      eff_part = DEF_PART;
      eff_grp  = DEF_GRP;
      eff_spc  = buf_pas;
    end
  end

endmodule

// File: rtl/trc_label_gate.sv
module trc_label_gate
  import trc_label_pkg::*;
#(
  parameter bit HAS_SECURE = 1'b1,
  parameter bit HAS_REALM  = 1'b1
) (
  input  logic       ext_act,
  input  logic [1:0] eff_spc,
  input  logic       dbg_all,
  input  logic       dbg_sec,
  input  logic       dbg_root,
  input  logic       dbg_realm,
  input  logic       beat_vld,
  output logic       beat_blocked,
  output logic       beat_wr,
  output logic       beat_drop_evt
);

  logic spc_bad;
  logic spc_deny;

  assign spc_bad  = spc_reserved(eff_spc, HAS_SECURE, HAS_REALM);
  assign spc_deny = spc_denied(eff_spc, HAS_SECURE, HAS_REALM,
                               dbg_all, dbg_sec, dbg_root, dbg_realm);

  assign beat_blocked  = ext_act && (spc_bad || spc_deny);
  assign beat_wr       = beat_vld && !beat_blocked;
  assign beat_drop_evt = beat_vld && beat_blocked;

endmodule

// File: rtl/trc_label_reg.sv
module trc_label_reg
  import trc_label_pkg::*;
#(
  parameter int unsigned PART_MAX   = 15,
  parameter int unsigned GRP_MAX    = 3,
  parameter bit          HAS_SECURE = 1'b1,
  parameter bit          HAS_REALM  = 1'b1,
  parameter bit          HAS_EXT    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  input  logic        mode_ext,
  input  logic        buf_en,
  input  logic        xbuf_en,
  input  logic        dbg_all,
  input  logic        dbg_sec,
  input  logic        dbg_root,
  input  logic        dbg_realm,
  input  logic [1:0]  buf_pas,
  input  logic        beat_vld,
  output logic        beat_wr,
  output logic        beat_drop_evt,
  output logic [15:0] out_part,
  output logic [7:0]  out_grp,
  output logic [1:0]  out_spc
);

  localparam int PW = (PART_MAX < 1) ? 1 : $clog2(PART_MAX + 1);
  localparam int GW = (GRP_MAX < 1) ? 1 : $clog2(GRP_MAX + 1);

  logic          wr_accept;
  logic          ext_act;
  logic          beat_blocked;
  logic          lab_en;
  logic [1:0]    lab_spc;
  logic [GW-1:0] lab_grp;
  logic [PW-1:0] lab_part;
  logic          unused_wbits;

  assign ext_act      = HAS_EXT && mode_ext;
  assign unused_wbits = ^cfg_wdata[63:EN_BIT+1];

  trc_label_store #(.PW(PW), .GW(GW), .HAS_EXT(HAS_EXT)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .w_en      (cfg_wdata[EN_BIT]),
    .w_spc     (cfg_wdata[SPC_LSB+1:SPC_LSB]),
    .w_grp     (cfg_wdata[GRP_LSB+7:GRP_LSB]),
    .w_part    (cfg_wdata[15:0]),
    .mode_ext  (mode_ext),
    .buf_en    (buf_en),
    .xbuf_en   (xbuf_en),
    .wr_accept (wr_accept),
    .lab_en    (lab_en),
    .lab_spc   (lab_spc),
    .lab_grp   (lab_grp),
    .lab_part  (lab_part)
  );

  trc_label_sel #(.PW(PW), .GW(GW)) u_sel (
    .ext_act  (ext_act),
    .lab_en   (lab_en),
    .lab_spc  (lab_spc),
    .lab_grp  (lab_grp),
    .lab_part (lab_part),
    .buf_pas  (buf_pas),
    .eff_part (out_part),
    .eff_grp  (out_grp),
    .eff_spc  (out_spc)
  );

  trc_label_gate #(.HAS_SECURE(HAS_SECURE), .HAS_REALM(HAS_REALM)) u_gate (
    .ext_act       (ext_act),
    .eff_spc       (out_spc),
    .dbg_all       (dbg_all),
    .dbg_sec       (dbg_sec),
    .dbg_root      (dbg_root),
    .dbg_realm     (dbg_realm),
    .beat_vld      (beat_vld),
    .beat_blocked  (beat_blocked),
    .beat_wr       (beat_wr),
    .beat_drop_evt (beat_drop_evt)
  );

  assign cfg_rdata = {37'd0, lab_en, lab_spc, 8'(lab_grp), 16'(lab_part)};

endmodule

// File: rtl/trc_label_chk.sv
module trc_label_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_accept,
  input logic        ext_act,
  input logic [2:0]  w_top,
  input logic [63:0] cfg_rdata,
  input logic        dbg_all,
  input logic        beat_vld,
  input logic        beat_wr,
  input logic        beat_drop_evt,
  input logic [15:0] out_part,
  input logic [7:0]  out_grp
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst_n;

  // R2
  rst_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> !cfg_rdata[26]);

  // R4
  ign_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(cfg_rdata));

  // R5
  acc_wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> cfg_rdata[26:24] == $past(w_top));

  // R8
  self_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_act && beat_vld) |-> (beat_wr && out_part == 16'd0 && out_grp == 8'd0));

  // R10
  dbg_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_act && beat_vld && !dbg_all) |-> beat_drop_evt);

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> $countones({beat_wr, beat_drop_evt}) == 1);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |-> !(beat_wr || beat_drop_evt));

endmodule

bind trc_label_reg trc_label_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_accept     (wr_accept),
  .ext_act       (ext_act),
  .w_top         (cfg_wdata[26:24]),
  .cfg_rdata     (cfg_rdata),
  .dbg_all       (dbg_all),
  .beat_vld      (beat_vld),
  .beat_wr       (beat_wr),
  .beat_drop_evt (beat_drop_evt),
  .out_part      (out_part),
  .out_grp       (out_grp)
);

// File: tb/trc_label_reg_tb.sv
module trc_label_reg_tb;

  localparam int PMAX = 12;
  localparam int GMAX = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cfg_wr, mode_ext, buf_en, xbuf_en;
  logic        dbg_all, dbg_sec, dbg_root, dbg_realm, beat_vld;
  logic [63:0] cfg_wdata;
  logic [1:0]  buf_pas;

  logic [63:0] d_rd, a_rd, n_rd;
  logic        d_wr, a_wr, n_wr, d_ev, a_ev, n_ev;
  logic [15:0] d_pt, a_pt, n_pt;
  logic [7:0]  d_gp, a_gp, n_gp;
  logic [1:0]  d_sp, a_sp, n_sp;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_m, exp_n;

  trc_label_reg #(.PART_MAX(PMAX), .GRP_MAX(GMAX), .HAS_SECURE(1'b1),
                  .HAS_REALM(1'b1), .HAS_EXT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(d_rd), .mode_ext(mode_ext), .buf_en(buf_en), .xbuf_en(xbuf_en),
    .dbg_all(dbg_all), .dbg_sec(dbg_sec), .dbg_root(dbg_root),
    .dbg_realm(dbg_realm), .buf_pas(buf_pas), .beat_vld(beat_vld),
    .beat_wr(d_wr), .beat_drop_evt(d_ev), .out_part(d_pt), .out_grp(d_gp),
    .out_spc(d_sp));

  trc_label_reg #(.PART_MAX(PMAX), .GRP_MAX(GMAX), .HAS_SECURE(1'b0),
                  .HAS_REALM(1'b0), .HAS_EXT(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(a_rd), .mode_ext(mode_ext), .buf_en(buf_en), .xbuf_en(xbuf_en),
    .dbg_all(dbg_all), .dbg_sec(dbg_sec), .dbg_root(dbg_root),
    .dbg_realm(dbg_realm), .buf_pas(buf_pas), .beat_vld(beat_vld),
    .beat_wr(a_wr), .beat_drop_evt(a_ev), .out_part(a_pt), .out_grp(a_gp),
    .out_spc(a_sp));

  trc_label_reg #(.PART_MAX(PMAX), .GRP_MAX(GMAX), .HAS_SECURE(1'b1),
                  .HAS_REALM(1'b1), .HAS_EXT(1'b0)) u_nx (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(n_rd), .mode_ext(mode_ext), .buf_en(buf_en), .xbuf_en(xbuf_en),
    .dbg_all(dbg_all), .dbg_sec(dbg_sec), .dbg_root(dbg_root),
    .dbg_realm(dbg_realm), .buf_pas(buf_pas), .beat_vld(beat_vld),
    .beat_wr(n_wr), .beat_drop_evt(n_ev), .out_part(n_pt), .out_grp(n_gp),
    .out_spc(n_sp));

  function automatic logic [15:0] lowmask(input int mx);
    int b;
    b = 1;
    while ((1 << b) <= mx) b++;
    return 16'((1 << b) - 1);
  endfunction

  function automatic logic [63:0] rd_of(input logic [63:0] v);
    logic [15:0] gm;
    gm = lowmask(GMAX);
    return {37'd0, v[26], v[25:24], v[23:16] & gm[7:0], v[15:0] & lowmask(PMAX)};
  endfunction

  function automatic bit accepts(input bit has_ext);
    return !((buf_en && (!has_ext || !mode_ext)) || (xbuf_en && has_ext && mode_ext));
  endfunction

  function automatic bit resv(input logic [1:0] s, input bit sec, input bit rlm);
    return (s == 2'd0 && !sec) || (s >= 2'd2 && !rlm);
  endfunction

  function automatic bit deny(input logic [1:0] s, input bit sec, input bit rlm,
                              input logic [3:0] dg);
    return !dg[0] || (sec && !dg[1] && s == 2'd0) ||
           (rlm && !dg[2] && s == 2'd2) || (rlm && !dg[3] && s == 2'd3);
  endfunction

  function automatic logic [27:0] beat_exp(input logic [63:0] r, input bit sec,
      input bit rlm, input bit md, input logic [1:0] pas, input logic [3:0] dg,
      input bit vld);
    logic [15:0] p; logic [7:0] g; logic [1:0] s; bit bad;
    logic [63:0] rr;
    rr = rd_of(r);
    if (md && rr[26]) begin p = rr[15:0]; g = rr[23:16]; s = rr[25:24]; end
    else begin p = 16'd0; g = 8'd0; s = pas; end
    bad = md && (resv(s, sec, rlm) || deny(s, sec, rlm, dg));
    return {p, g, s, vld && !bad, vld && bad};
  endfunction

  function automatic string beat_tag(input logic [63:0] r, input bit sec,
      input bit rlm, input bit md, input logic [1:0] pas, input logic [3:0] dg,
      input bit vld);
    logic [1:0] s;
    s = (md && r[26]) ? r[25:24] : pas;
    if (!vld) return "R11";
    if (!md) return "R8";
    if (resv(s, sec, rlm)) return "R9";
    if (deny(s, sec, rlm, dg)) return "R10";
    return r[26] ? "R7" : "R6";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [63:0] d, input string tag);
    bit am, an;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    am = accepts(1'b1); an = accepts(1'b0);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (am) exp_m = d;
    if (an) exp_n = d;
    #1;
    chk({tag, " main"}, d_rd, rd_of(exp_m));
    chk({tag, " noext"}, n_rd, rd_of(exp_n));
  endtask

  task automatic sweep();
    for (int md = 0; md < 2; md++)
      for (int pas = 0; pas < 4; pas++)
        for (int dg = 0; dg < 16; dg++)
          for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            mode_ext = md[0]; buf_pas = pas[1:0];
            {dbg_realm, dbg_root, dbg_sec, dbg_all} = dg[3:0];
            beat_vld = v[0];
            #1;
            chk(beat_tag(exp_m, 1, 1, md[0], pas[1:0], dg[3:0], v[0]),
                64'({d_pt, d_gp, d_sp, d_wr, d_ev}),
                64'(beat_exp(exp_m, 1, 1, md[0], pas[1:0], dg[3:0], v[0])));
            chk(beat_tag(exp_m, 0, 0, md[0], pas[1:0], dg[3:0], v[0]),
                64'({a_pt, a_gp, a_sp, a_wr, a_ev}),
                64'(beat_exp(exp_m, 0, 0, md[0], pas[1:0], dg[3:0], v[0])));
          end
    beat_vld = 1'b0; mode_ext = 1'b0;
  endtask

  function automatic logic [63:0] word(input bit en, input logic [1:0] s,
                                       input logic [7:0] g, input logic [15:0] p);
    return {37'h1F_FFFF_FFFF, en, s, g, p};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; mode_ext = 1'b0;
    buf_en = 1'b0; xbuf_en = 1'b0; dbg_all = 1'b1; dbg_sec = 1'b1;
    dbg_root = 1'b1; dbg_realm = 1'b1; buf_pas = 2'd1; beat_vld = 1'b0;
    exp_m = '0; exp_n = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2: enable clear after reset
    chk("R2 dut", 64'(d_rd[26]), 64'd0);
    chk("R2 alt", 64'(a_rd[26]), 64'd0);
    chk("R2 noext", 64'(n_rd[26]), 64'd0);

    // R1 R3: all-ones write, reserved and excess bits read as zero
    do_wr(word(1'b1, 2'b01, 8'hFF, 16'hFFFF), "R1 R3");
    chk("R1 R3 direct", d_rd, {37'd0, 1'b1, 2'b01, 8'h03, 16'h000F});

    // R4: buffer enabled in self-hosted mode
    buf_en = 1'b1; mode_ext = 1'b0;
    do_wr(word(1'b0, 2'b10, 8'h01, 16'h0003), "R4 self-hosted");
    // R4: buffer enabled in external mode, only the no-ext build drops it
    mode_ext = 1'b1;
    do_wr(word(1'b0, 2'b11, 8'h02, 16'h0005), "R4 ext-unsupported");
    // R5: external enable in external mode
    buf_en = 1'b0; xbuf_en = 1'b1;
    do_wr(word(1'b1, 2'b00, 8'h01, 16'h0007), "R5 ext-enabled");
    // R5: external enable in self-hosted mode has no blocking effect
    mode_ext = 1'b0;
    do_wr(word(1'b1, 2'b10, 8'h03, 16'h0009), "R5 self-hosted");
    xbuf_en = 1'b0;

    // R6 R8 R9 R10 R11: enable clear
    do_wr(word(1'b0, 2'b11, 8'h01, 16'h0009), "R5 setup");
    sweep();
    // R7 R9 R10 R11: enable set, every space
    for (int s = 0; s < 4; s++) begin
      do_wr(word(1'b1, s[1:0], 8'h02, 16'h1234), "R5 setup");
      sweep();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule